// File: doc/BRIEF.md
# Multicore Reset and Boot Controller

This block is a word-addressed register file that software uses to start, stop and reset up to four processor cores. It holds sixteen 32-bit registers: a control word, two boot-mode words, a reset-status word, an interrupt-status word, an interrupt-mask word and ten general-purpose words. Registers 6 through 15 are the general-purpose words GP1 to GP10. Each secondary core takes its start address and start argument from a fixed pair of these general-purpose words.

When software writes the control word, the block XORs the old and new values. Each changed per-core bit becomes a command: power on, power off or reset. The command goes into a small queue for that core and is offered on a request/acknowledge handshake that carries an opcode, an entry address and an argument. While any command for a core is outstanding, that core's reset bit reads back as 1. It falls to 0 on the acknowledge that empties the core's queue. Two peripheral reset bits behave as self-clearing bits. The block has no interrupt logic, and it models neither the cores nor any boot code.

Top module: `mrc_reset_ctrl`

## Requirements
- R1: After reset, the control word reads 0x0000_0521, register 2 reads 0x1, register 4 reads 0x1F, every other register reads 0, and no core request is raised.
- R2: The register index is the byte address divided by four (address bits 11:2). A write to any in-range index other than 0 stores the written word unchanged, and a later read of that index returns it.
- R3: A read at an index of 16 or more returns 0. A write at such an index changes no register and issues no command.
- R4: Only control bits whose written value differs from the current read-back value cause an action. Rewriting the current value issues no command.
- R5: For core k (k = 1, 2, 3), a change of enable bit 21+k issues a command. The command is ON (opcode 1) when the new bit is 1. ON carries entry address = register 6+2k and argument = register 7+2k, which are GP(2k+1) and GP(2k+2). The command is OFF (opcode 2) when the new bit is 0, and OFF carries entry and argument 0. The enable bit reads back as written.
- R6: A change of reset bit 13+k issues a reset command (opcode 3, entry 0, argument 0) to core k. Core 0 has only this bit. For cores 1 to 3, if the enable bit changes in the same write, only the enable command is issued.
- R7: When a write issues a command to core k, bit 13+k reads 1 from the next cycle. It stays 1 until the acknowledge that drains the last queued command for core k, and reads 0 from the cycle after that acknowledge. Software cannot otherwise set or clear this bit.
- R8: core_req[k] stays high, with opcode, entry and argument unchanged, until a one-cycle core_ack[k] pulse. The acknowledge retires that command.
- R9: Commands for a core are kept in issue order, up to QDEPTH of them. A command issued while the core's queue is full is dropped.
- R10: Control bits 3 and 12 always read 0. Any write that changes them stores 0.
- R11: Every control bit other than 3, 12, 13 to 16 and 22 to 24 is plain storage and reads back as last written.
- R12: The entry address and argument of a command are captured when the control write occurs. A later write to the general-purpose words does not alter a command that is already queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Access strobe for one aligned 32-bit access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address inside the 4 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational; 0 when not reading or out of range |
| core_req | output | 4 | Per-core command request |
| core_op | output | 8 | Per-core opcode, 2 bits per core (1 on, 2 off, 3 reset) |
| core_entry | output | 128 | Per-core entry address, 32 bits per core |
| core_arg | output | 128 | Per-core start argument, 32 bits per core |
| core_ack | input | 4 | Per-core one-cycle completion pulse |

## Verification
The bench goes after the following corner cases:
- One write changes both a core's enable bit and its reset bit. A design that fails to suppress the reset would emit a surplus reset command, which the scoreboard rejects as unexpected.
- A core's acknowledge is withheld while four commands pile up, followed by a fifth. A design with a shallow or overwriting queue would lose or reorder commands. A design that clears the busy bit on the first acknowledge would read 0 too early.
- A general-purpose word is rewritten while a start command is queued. This exposes a design that samples the entry address at handshake time instead of at write time.
- Out-of-range accesses, rewrites of the current control value and writes to the self-clearing peripheral bits are all checked at the read port and the request lines. Leaks there would show as nonzero data or stray requests.

// File: rtl/mrc_pkg.sv
package mrc_pkg;

  localparam int unsigned DW      = 32;
  localparam int unsigned NREGS   = 16;
  localparam int unsigned IDX_W   = $clog2(NREGS);
  localparam int unsigned NCORES  = 4;

  localparam int unsigned IDX_CTRL  = 0;
  localparam int unsigned IDX_RSTAT = 2;
  localparam int unsigned IDX_IMASK = 4;
  localparam int unsigned IDX_GP0   = 6;

  localparam logic [DW-1:0] CTRL_INIT  = 32'h0000_0521;
  localparam logic [DW-1:0] RSTAT_INIT = 32'h0000_0001;
  localparam logic [DW-1:0] IMASK_INIT = 32'h0000_001F;

  localparam int unsigned PERIPH_A_BIT = 3;
  localparam int unsigned PERIPH_B_BIT = 12;
  localparam int unsigned CORE_RST_LSB = 13;
  localparam int unsigned CORE_EN_BASE = 21;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ON   = 2'd1,
    OP_OFF  = 2'd2,
    OP_RST  = 2'd3
  } core_op_e;

  typedef struct packed {
    core_op_e        op;
    logic [DW-1:0]   entry;
    logic [DW-1:0]   arg;
  } core_cmd_t;

endpackage

// File: rtl/mrc_cmd_decode.sv
module mrc_cmd_decode
  import mrc_pkg::*;
(
  input  logic                    ctrl_we,
  input  logic [DW-1:0]           ctrl_old,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           ctrl_base,
  output logic [NCORES-1:0]       issue,
  output logic [NCORES-1:0][1:0]  issue_op
);

  logic [DW-1:0] chg;

  // Stored control value before busy-bit overrides.
  always_comb begin
    chg       = ctrl_old ^ wdata;
    ctrl_base = wdata;
    ctrl_base[PERIPH_A_BIT] = chg[PERIPH_A_BIT] ? 1'b0 : ctrl_old[PERIPH_A_BIT];
    ctrl_base[PERIPH_B_BIT] = chg[PERIPH_B_BIT] ? 1'b0 : ctrl_old[PERIPH_B_BIT];
    ctrl_base[CORE_RST_LSB +: NCORES] = ctrl_old[CORE_RST_LSB +: NCORES];
  end

  for (genvar g = 0; g < NCORES; g++) begin : g_core
    if (g == 0) begin : g_rst_only
      assign issue[g]    = ctrl_we && chg[CORE_RST_LSB + g];
      assign issue_op[g] = OP_RST;
    end else begin : g_en_rst
      logic en_chg;
      assign en_chg      = chg[CORE_EN_BASE + g];
      assign issue[g]    = ctrl_we && (en_chg || chg[CORE_RST_LSB + g]);
      assign issue_op[g] = !en_chg ? OP_RST
                         : (wdata[CORE_EN_BASE + g] ? OP_ON : OP_OFF);
    end
  end

endmodule

// File: rtl/mrc_core_queue.sv
module mrc_core_queue
  import mrc_pkg::*;
#(
  parameter int unsigned QDEPTH = 4
)
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  core_cmd_t push_cmd,
  input  logic      ack,
  output logic      req,
  output core_cmd_t head_cmd,
  output logic      drained
);

  localparam int unsigned PTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(QDEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(QDEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(QDEPTH);

  core_cmd_t        slot_q [QDEPTH];
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d, wr_ptr_q, wr_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full, pop, push_ok, ptr_en;

  always_comb begin
    full     = (cnt_q == FULL_CNT);
    pop      = ack && (cnt_q != '0);
    push_ok  = push && !full;
    rd_ptr_d = rd_ptr_q;
    wr_ptr_d = wr_ptr_q;
    cnt_d    = cnt_q;
    if (pop)     rd_ptr_d = (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + PTR_W'(1);
    if (push_ok) wr_ptr_d = (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + PTR_W'(1);
    case ({push_ok, pop})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
    ptr_en  = push_ok | pop;
    drained = pop && !push_ok && (cnt_q == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (ptr_en) begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) slot_q[wr_ptr_q] <= push_cmd;
  end

  assign req      = (cnt_q != '0);
  assign head_cmd = slot_q[rd_ptr_q];

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (req && $stable(head_cmd)));

  assert_full_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !ack) |=> ((cnt_q == FULL_CNT) && $stable(wr_ptr_q)));

endmodule

// File: rtl/mrc_regfile.sv
module mrc_regfile
  import mrc_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [DW-1:0]                wr_data,
  input  logic [DW-1:0]                ctrl_base,
  input  logic [NCORES-1:0]            issue,
  input  logic [NCORES-1:0]            drained,
  output logic [NREGS-1:0][DW-1:0]     regs_q
);

  function automatic logic [DW-1:0] reset_word(input int unsigned i);
    case (i)
      IDX_CTRL:  return CTRL_INIT;
      IDX_RSTAT: return RSTAT_INIT;
      IDX_IMASK: return IMASK_INIT;
      default:   return '0;
    endcase
  endfunction

  logic [NREGS-1:0][DW-1:0] regs_d;
  logic                     reg_en;

  always_comb begin
    regs_d = regs_q;
    if (wr_en) begin
      if (wr_idx == IDX_W'(IDX_CTRL)) regs_d[IDX_CTRL] = ctrl_base;
      else                            regs_d[wr_idx]   = wr_data;
    end
    for (int c = 0; c < NCORES; c++) begin
      if (issue[c])        regs_d[IDX_CTRL][CORE_RST_LSB + c] = 1'b1;
      else if (drained[c]) regs_d[IDX_CTRL][CORE_RST_LSB + c] = 1'b0;
    end
    reg_en = wr_en | (|issue) | (|drained);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREGS; r++) regs_q[r] <= reset_word(r);
    end else if (reg_en) begin
      regs_q <= regs_d;
    end
  end

  assert_plain_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx != IDX_W'(IDX_CTRL))) |=> (regs_q[$past(wr_idx)] == $past(wr_data)));

  assert_periph_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!regs_q[IDX_CTRL][PERIPH_A_BIT] && !regs_q[IDX_CTRL][PERIPH_B_BIT]));

endmodule

// File: rtl/mrc_reset_ctrl.sv
module mrc_reset_ctrl
  import mrc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned QDEPTH = 4
)
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel,
  input  logic                     bus_write,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DW-1:0]            bus_wdata,
  output logic [DW-1:0]            bus_rdata,
  output logic [NCORES-1:0]        core_req,
  output logic [2*NCORES-1:0]      core_op,
  output logic [DW*NCORES-1:0]     core_entry,
  output logic [DW*NCORES-1:0]     core_arg,
  input  logic [NCORES-1:0]        core_ack
);

  localparam int unsigned WIDX_W = ADDR_W - 2;

  // Reset: asynchronous assertion, two-flop synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Address decode.
  logic [WIDX_W-1:0] word_idx;
  logic              idx_ok;
  logic [IDX_W-1:0]  reg_idx;
  logic              wr_en, ctrl_we;
  logic              unused_addr_lo;

  assign word_idx       = bus_addr[ADDR_W-1:2];
  assign idx_ok         = (word_idx < WIDX_W'(NREGS));
  assign reg_idx        = word_idx[IDX_W-1:0];
  assign unused_addr_lo = ^bus_addr[1:0];
  assign wr_en          = bus_sel && bus_write && idx_ok;
  assign ctrl_we        = wr_en && (reg_idx == IDX_W'(IDX_CTRL));

  logic [NREGS-1:0][DW-1:0]  regs_q;
  logic [DW-1:0]             ctrl_base;
  logic [NCORES-1:0]         issue, drained;
  logic [NCORES-1:0][1:0]    issue_op;

  mrc_cmd_decode u_decode (
    .ctrl_we   (ctrl_we),
    .ctrl_old  (regs_q[IDX_CTRL]),
    .wdata     (bus_wdata),
    .ctrl_base (ctrl_base),
    .issue     (issue),
    .issue_op  (issue_op)
  );

  mrc_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (wr_en),
    .wr_idx    (reg_idx),
    .wr_data   (bus_wdata),
    .ctrl_base (ctrl_base),
    .issue     (issue),
    .drained   (drained),
    .regs_q    (regs_q)
  );

  assign bus_rdata = (bus_sel && !bus_write && idx_ok) ? regs_q[reg_idx] : '0;

  for (genvar g = 0; g < NCORES; g++) begin : g_core
    core_cmd_t     push_cmd, head_cmd;
    logic [DW-1:0] entry_sel, arg_sel;

    if (g == 0) begin : g_no_boot
      assign entry_sel = '0;
      assign arg_sel   = '0;
    end else begin : g_boot
      assign entry_sel = (issue_op[g] == OP_ON) ? regs_q[IDX_GP0 + 2*g]     : '0;
      assign arg_sel   = (issue_op[g] == OP_ON) ? regs_q[IDX_GP0 + 2*g + 1] : '0;
    end

    assign push_cmd = {issue_op[g], entry_sel, arg_sel};

    mrc_core_queue #(.QDEPTH(QDEPTH)) u_queue (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .push     (issue[g]),
      .push_cmd (push_cmd),
      .ack      (core_ack[g]),
      .req      (core_req[g]),
      .head_cmd (head_cmd),
      .drained  (drained[g])
    );

    assign core_op[2*g +: 2]     = head_cmd.op;
    assign core_entry[DW*g +: DW] = head_cmd.entry;
    assign core_arg[DW*g +: DW]   = head_cmd.arg;

    assert_busy_bit_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
      core_req[g] |-> regs_q[IDX_CTRL][CORE_RST_LSB + g]);

    if (g != 0) begin : g_en_chk
      assert_en_start_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
        (ctrl_we && !core_req[g] && !regs_q[IDX_CTRL][CORE_EN_BASE + g]
         && bus_wdata[CORE_EN_BASE + g])
        |=> (core_req[g] && (core_op[2*g +: 2] == OP_ON)));
    end
  end

  assert_oob_read_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_sel && !bus_write && !idx_ok) |-> (bus_rdata == '0));

  assert_same_write_quiet_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctrl_we && (bus_wdata == regs_q[IDX_CTRL]) && (core_req == '0)) |=> (core_req == '0));

endmodule

// File: tb/mrc_reset_ctrl_tb_top.sv
module mrc_reset_ctrl_tb_top;

  localparam int QD = 4;

  logic         clk;
  logic         rst_n;
  logic         bus_sel, bus_write;
  logic [11:0]  bus_addr;
  logic [31:0]  bus_wdata, bus_rdata;
  logic [3:0]   core_req, core_ack;
  logic [7:0]   core_op;
  logic [127:0] core_entry, core_arg;

  mrc_reset_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_req(core_req), .core_op(core_op), .core_entry(core_entry),
    .core_arg(core_arg), .core_ack(core_ack)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 1'b0;
  logic [31:0] m_regs [16];
  logic [65:0] expq [4][$];
  logic [3:0]  ack_en;
  logic [65:0] got, expv;

  task automatic chk(input bit ok, input string tag, input logic [65:0] act, input logic [65:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic bus_wr(input logic [11:0] addr, input logic [31:0] val);
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = addr; bus_wdata = val;
    @(negedge clk);
    bus_sel = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] addr, input logic [31:0] exp, input string tag);
    bus_sel = 1'b1; bus_write = 1'b0; bus_addr = addr;
    #2;
    chk(bus_rdata == exp, tag, {34'd0, bus_rdata}, {34'd0, exp});
    bus_sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic reg_wr(input int idx, input logic [31:0] val);
    m_regs[idx] = val;
    bus_wr(12'(idx * 4), val);
  endtask

  // Driver: model the control write and push the expected commands.
  task automatic ctrl_write(input logic [31:0] val);
    logic [31:0] chg, nv;
    logic [1:0]  op;
    logic [31:0] ent, arg;
    chg = m_regs[0] ^ val;
    nv  = val;
    nv[3]  = chg[3]  ? 1'b0 : m_regs[0][3];
    nv[12] = chg[12] ? 1'b0 : m_regs[0][12];
    for (int c = 0; c < 4; c++) begin
      nv[13+c] = m_regs[0][13+c];
      op = 2'd0;
      if (c > 0 && chg[21+c]) op = val[21+c] ? 2'd1 : 2'd2;
      else if (chg[13+c])     op = 2'd3;
      if (op != 2'd0) begin
        ent = (op == 2'd1) ? m_regs[6+2*c] : 32'd0;
        arg = (op == 2'd1) ? m_regs[7+2*c] : 32'd0;
        if (expq[c].size() < QD) expq[c].push_back({op, ent, arg});
        nv[13+c] = 1'b1;
      end
    end
    m_regs[0] = nv;
    bus_wr(12'h000, val);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (core_req == 4'd0 && core_ack == 4'd0 && expq[0].size() == 0 &&
          expq[1].size() == 0 && expq[2].size() == 0 && expq[3].size() == 0) break;
    end
    @(negedge clk);
    chk(core_req == 4'd0, "R8 drain", {62'd0, core_req}, 66'd0);
  endtask

  // Monitor: pop expected commands as the design offers them.
  initial begin
    core_ack = 4'd0;
    forever begin
      @(negedge clk);
      for (int c = 0; c < 4; c++) begin
        if (core_ack[c]) core_ack[c] = 1'b0;
        else if (core_req[c] && ack_en[c]) begin
          got = {core_op[2*c +: 2], core_entry[32*c +: 32], core_arg[32*c +: 32]};
          if (expq[c].size() == 0) begin
            chk(1'b0, "R8 unexpected command", got, 66'd0);
          end else begin
            expv = expq[c].pop_front();
            chk(got == expv, "R8 command content/order", got, expv);
            if (expq[c].size() == 0) m_regs[0][13+c] = 1'b0;
          end
          core_ack[c] = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bus_sel = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    ack_en = 4'hF;
    for (int i = 0; i < 16; i++) m_regs[i] = 32'd0;
    m_regs[0] = 32'h521; m_regs[2] = 32'h1; m_regs[4] = 32'h1F;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(core_req == 4'd0, "R1 no request", {62'd0, core_req}, 66'd0);
    for (int i = 0; i < 16; i++) rd_chk(12'(i * 4), m_regs[i], "R1 reset value");

    // R2 plain storage
    for (int i = 1; i < 16; i++) reg_wr(i, (32'h1000_0000 * i) ^ (32'h0101 * i) ^ 32'hA5A5_0000);
    for (int i = 1; i < 16; i++) rd_chk(12'(i * 4), m_regs[i], "R2 readback");

    // R3 out of range
    bus_wr(12'h040, 32'hDEAD_BEEF);
    bus_wr(12'hFFC, 32'hCAFE_F00D);
    rd_chk(12'h040, 32'd0, "R3 oob read");
    rd_chk(12'hFFC, 32'd0, "R3 oob read");
    rd_chk(12'h03C, m_regs[15], "R3 no side effect");
    rd_chk(12'h000, m_regs[0], "R3 no side effect");
    chk(core_req == 4'd0, "R3 no command", {62'd0, core_req}, 66'd0);

    // R5 / R7 start core 1 with acknowledge withheld
    ack_en[1] = 1'b0;
    ctrl_write(m_regs[0] | (32'd1 << 22));
    repeat (3) @(negedge clk);
    rd_chk(12'h000, m_regs[0], "R7 busy bit set");
    chk(core_req[1] == 1'b1, "R8 request held", {65'd0, core_req[1]}, 66'd1);
    ack_en[1] = 1'b1;
    wait_idle();
    rd_chk(12'h000, m_regs[0], "R7 busy bit cleared, R5 enable kept");

    // R4 rewrite of the current value
    ctrl_write(m_regs[0]);
    repeat (5) @(negedge clk);
    chk(core_req == 4'd0, "R4 no command on same value", {62'd0, core_req}, 66'd0);

    // R5 stop core 1
    ctrl_write(m_regs[0] & ~(32'd1 << 22));
    wait_idle();

    // R6 core 0 reset, core 2 enable and reset in one write
    ctrl_write(m_regs[0] | (32'd1 << 13) | (32'd1 << 23) | (32'd1 << 15));
    wait_idle();
    rd_chk(12'h000, m_regs[0], "R6 control after reset/enable mix");

    // R9 / R12 queue on core 3
    ack_en[3] = 1'b0;
    ctrl_write(m_regs[0] | (32'd1 << 24));        // ON, old GP7
    reg_wr(12, 32'h7777_1234);                    // R12 change after capture
    ctrl_write(m_regs[0] & ~(32'd1 << 24));       // OFF
    ctrl_write(m_regs[0] & ~(32'd1 << 16));       // RST
    ctrl_write(m_regs[0] | (32'd1 << 24));        // ON, new GP7
    ctrl_write(m_regs[0] & ~(32'd1 << 24));       // dropped: queue full
    chk(expq[3].size() == QD, "R9 model depth", 66'(expq[3].size()), 66'(QD));
    rd_chk(12'h000, m_regs[0], "R7 busy while queued");
    ack_en[3] = 1'b1;
    wait_idle();
    rd_chk(12'h000, m_regs[0], "R9 control after drain");

    // R10 self-clearing peripheral bits
    ctrl_write(m_regs[0] | (32'd1 << 3) | (32'd1 << 12));
    rd_chk(12'h000, m_regs[0], "R10 peripheral bits read 0");
    chk(core_req == 4'd0, "R10 no command", {62'd0, core_req}, 66'd0);

    // R11 plain control bits
    begin
      logic [31:0] plain;
      plain = ~((32'd1 << 3) | (32'd1 << 12) | (32'hF << 13) | (32'h7 << 22));
      ctrl_write((32'hFFFF_FFFF & plain) | (m_regs[0] & ~plain));
      rd_chk(12'h000, m_regs[0], "R11 plain bits set");
      ctrl_write(m_regs[0] & ~plain);
      rd_chk(12'h000, m_regs[0], "R11 plain bits cleared");
      repeat (5) @(negedge clk);
      chk(core_req == 4'd0, "R11 no command", {62'd0, core_req}, 66'd0);
    end

    finish_run();
  end

endmodule